// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block is the register file behind a general-purpose I/O controller with 95 pads. A host reaches it through a plain 32-bit bus. The bus has a word address, a write strobe and write data, and returns read data one cycle later. Each pad has two configuration words of its own. The first word holds the drive level, direction, function select and trigger style. The second word holds the weak pull and an input-sense disable. A small set of bitmap registers is shared by all pads: an ownership map, a routing map toward an interrupt controller, a global configuration word, and the interrupt status and enable words.

The block turns its stored configuration into per-pad control lines: output level, output enable, function select, pull-up, pull-down, sense enable and trigger style. It brings each pad's input level through a two-stage synchronizer so that software can read it. Interrupt status and enable bits are kept by a neighbouring block. This bank only decodes their addresses. It returns the neighbour's bits on a read, and it passes a write on as a one-cycle strobe with the word index and the data.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, every pad is a GPIO-mode input with sensing off and no pull. The first configuration word reads 0x00000005, the second reads 0x00000004, output enables are low, and the ownership map is all zero.
- R2: The first configuration word of pin p sits at byte offset 0x100 + 8p (word address 0x40 + 2p). Bit 31 is the output level. Bit 4 selects the trigger style (1 level, 0 edge). Bit 3 inverts the trigger. Bit 2 sets the direction (1 input). Bits 1:0 hold the use select (01 is GPIO). Bit 30 is read-only, and a write to it is ignored.
- R3: A pad's output enable is high only when its use select is 01 and its direction bit is 0. The pad's output level follows bit 31.
- R4: The second word of pin p sits at byte offset 0x104 + 8p. Bits 1:0 select the pull: 01 gives pull-down, 10 gives pull-up, and 00 or 11 gives neither. Bit 2 set turns input sensing off, and the sense-enable output is its inverse.
- R5: While sensing is on, bit 30 of the first word shows the pad input after two clock edges of synchronization. While sensing is off, bit 30 reads 0.
- R6: A write to one pin's word changes no other pin's controls. This holds up to the last pin, 94, whose second word is at word address 0xFD.
- R7: The ownership map occupies three words at byte offset 0x00. Pin p is bit p mod 32 of word p/32. It drives the per-pin ownership output. Bit 31 of the third word has no pin and reads 0.
- R8: The routing word at byte offset 0x10 keeps 16 bits. Bits 0-2 route pins 8-10, bits 3-4 route pins 13-14, and bits 5-15 route pins 45-55. No other pin is routed, and the upper 16 bits read 0.
- R9: The global configuration word at byte offset 0x7C is a full 32-bit read/write register. Its value is driven out of the block.
- R10: Interrupt status words at byte 0x80 and enable words at byte 0x90 read back the neighbour's input bits. A write to one of them produces, in the next cycle, a single strobe (status or enable) together with the word index and the data.
- R11: Offsets that are not mapped read 0, and a write to them changes nothing.
- R12: Read data is registered. It shows the word addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word address (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 95 | Raw pad input levels |
| pad_out | output | 95 | Pad output levels |
| pad_oe | output | 95 | Pad output enables |
| pad_pull_up | output | 95 | Weak pull-up enables |
| pad_pull_dn | output | 95 | Weak pull-down enables |
| pad_sense_en | output | 95 | Input-sense enables |
| pad_fsel | output | 190 | Use select, two bits per pin (pin p at bits 2p+1:2p) |
| trig_level | output | 95 | Trigger style per pin (1 level) |
| trig_inv | output | 95 | Trigger invert per pin |
| pin_owned | output | 95 | Ownership map |
| pin_route | output | 95 | Routing map expanded to pins |
| glb_cfg | output | 32 | Global configuration word |
| irq_stat_i | input | 95 | Status bits from the interrupt block |
| irq_en_i | input | 95 | Enable bits from the interrupt block |
| irq_wr_stat | output | 1 | Status word write strobe |
| irq_wr_en | output | 1 | Enable word write strobe |
| irq_wr_idx | output | 2 | Word index of the forwarded write |
| irq_wr_data | output | 32 | Data of the forwarded write |

## Verification
The hardest case to reach is the read-back of bit 30. It depends on three things at once: the sense-disable bit in the other word, a live pad input, and the two synchronizer stages. The stimulus first clears the disable bit through the second word, then drives the pad high, waits two edges, and reads the first word. It then sets the disable bit and reads again with the pad still high, so the only change is the gating. A write of 1 to bit 30 with the pad low confirms that the bit cannot be written. The mapping at the edges of the address space is also exercised: pin 94, the unused top bit of the third bitmap word, and holes between the bitmap bases.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  // Word addresses (byte offset / 4) of the register groups
  localparam int OWN_W   = 'h00;
  localparam int ROUTE_W = 'h04;
  localparam int GCFG_W  = 'h1F;
  localparam int STAT_W  = 'h20;
  localparam int EN_W    = 'h24;
  localparam int CFG_W   = 'h40;

  localparam int ROUTE_BITS = 16;
  localparam logic [1:0] USE_GPIO = 2'b01;
  localparam logic [1:0] PULL_DN  = 2'b01;
  localparam logic [1:0] PULL_UP  = 2'b10;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_lvl;
    logic       trig_inv;
    logic       dir_in;
    logic [1:0] use_sel;
    logic       sense_off;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{
    out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0, dir_in: 1'b1,
    use_sel: USE_GPIO, sense_off: 1'b1, pull: 2'b00};

  // Routing bit for a pin, or -1 when the pin has none
  function automatic int route_slot(int pin);
    if (pin >= 8 && pin <= 10)  return pin - 8;
    if (pin >= 13 && pin <= 14) return pin - 10;
    if (pin >= 45 && pin <= 55) return pin - 40;
    return -1;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 95
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_slot.sv
module gpio_pin_slot
  import gpio_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we_a,
  input  logic     we_b,
  input  pin_cfg_t wr_val,
  output pin_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else begin
      if (we_a) begin
        cfg.out_lvl  <= wr_val.out_lvl;
        cfg.trig_lvl <= wr_val.trig_lvl;
        cfg.trig_inv <= wr_val.trig_inv;
        cfg.dir_in   <= wr_val.dir_in;
        cfg.use_sel  <= wr_val.use_sel;
      end
      if (we_b) begin
        cfg.sense_off <= wr_val.sense_off;
        cfg.pull      <= wr_val.pull;
      end
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_pull_up,
  output logic [NUM_PINS-1:0]   pad_pull_dn,
  output logic [NUM_PINS-1:0]   pad_sense_en,
  output logic [2*NUM_PINS-1:0] pad_fsel,
  output logic [NUM_PINS-1:0]   trig_level,
  output logic [NUM_PINS-1:0]   trig_inv,
  output logic [NUM_PINS-1:0]   pin_owned,
  output logic [NUM_PINS-1:0]   pin_route,
  output logic [31:0]           glb_cfg,
  input  logic [NUM_PINS-1:0]   irq_stat_i,
  input  logic [NUM_PINS-1:0]   irq_en_i,
  output logic                  irq_wr_stat,
  output logic                  irq_wr_en,
  output logic [1:0]            irq_wr_idx,
  output logic [31:0]           irq_wr_data
);
  localparam int MAP_WORDS = (NUM_PINS + 31) / 32;
  localparam int MAP_BITS  = 32 * MAP_WORDS;
  localparam int CFG_LAST  = CFG_W + 2 * NUM_PINS - 1;
  localparam int PIN_IW    = $clog2(NUM_PINS);

  pin_cfg_t              cfg [NUM_PINS];
  pin_cfg_t              wr_val;
  logic [NUM_PINS-1:0]   in_q;
  logic [NUM_PINS-1:0]   own_q;
  logic [ROUTE_BITS-1:0] route_q;
  logic [31:0]           glb_q;
  logic [MAP_BITS-1:0]   own_pad, stat_pad, en_pad;
  logic [31:0]           rd_nx;
  logic [PIN_IW-1:0]     rd_idx;
  pin_cfg_t              rd_cfg;

  // Write data split into the per-pin fields of both words
  always_comb begin
    wr_val.out_lvl   = bus_wdata[31];
    wr_val.trig_lvl  = bus_wdata[4];
    wr_val.trig_inv  = bus_wdata[3];
    wr_val.dir_in    = bus_wdata[2];
    wr_val.use_sel   = bus_wdata[1:0];
    wr_val.sense_off = bus_wdata[2];
    wr_val.pull      = bus_wdata[1:0];
  end

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit_a, hit_b;
    assign hit_a = bus_we && (bus_addr == ADDR_W'(CFG_W + 2 * i));
    assign hit_b = bus_we && (bus_addr == ADDR_W'(CFG_W + 2 * i + 1));

    gpio_pin_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .we_a   (hit_a),
      .we_b   (hit_b),
      .wr_val (wr_val),
      .cfg    (cfg[i])
    );

    assign pad_out[i]        = cfg[i].out_lvl;
    assign pad_oe[i]         = (cfg[i].use_sel == USE_GPIO) && !cfg[i].dir_in;
    assign pad_pull_up[i]    = (cfg[i].pull == PULL_UP);
    assign pad_pull_dn[i]    = (cfg[i].pull == PULL_DN);
    assign pad_sense_en[i]   = !cfg[i].sense_off;
    assign pad_fsel[2*i +: 2] = cfg[i].use_sel;
    assign trig_level[i]     = cfg[i].trig_lvl;
    assign trig_inv[i]       = cfg[i].trig_inv;

    localparam int SLOT = route_slot(i);
    if (SLOT >= 0) begin : g_routed
      assign pin_route[i] = route_q[SLOT];
    end else begin : g_unrouted
      assign pin_route[i] = 1'b0;
    end
  end

  // Shared bitmap registers and write forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      own_q       <= '0;
      route_q     <= '0;
      glb_q       <= '0;
      irq_wr_stat <= 1'b0;
      irq_wr_en   <= 1'b0;
      irq_wr_idx  <= '0;
      irq_wr_data <= '0;
    end else begin
      irq_wr_stat <= 1'b0;
      irq_wr_en   <= 1'b0;
      for (int b = 0; b < NUM_PINS; b++) begin
        if (bus_we && bus_addr == ADDR_W'(OWN_W + b / 32))
          own_q[b] <= bus_wdata[b % 32];
      end
      if (bus_we && bus_addr == ADDR_W'(ROUTE_W))
        route_q <= bus_wdata[ROUTE_BITS-1:0];
      if (bus_we && bus_addr == ADDR_W'(GCFG_W))
        glb_q <= bus_wdata;
      for (int w = 0; w < MAP_WORDS; w++) begin
        if (bus_we && bus_addr == ADDR_W'(STAT_W + w)) begin
          irq_wr_stat <= 1'b1;
          irq_wr_idx  <= 2'(w);
          irq_wr_data <= bus_wdata;
        end
        if (bus_we && bus_addr == ADDR_W'(EN_W + w)) begin
          irq_wr_en   <= 1'b1;
          irq_wr_idx  <= 2'(w);
          irq_wr_data <= bus_wdata;
        end
      end
    end
  end

  assign pin_owned = own_q;
  assign glb_cfg   = glb_q;
  assign own_pad   = MAP_BITS'(own_q);
  assign stat_pad  = MAP_BITS'(irq_stat_i);
  assign en_pad    = MAP_BITS'(irq_en_i);

  // Read decode
  always_comb begin
    rd_nx  = '0;
    rd_idx = PIN_IW'((bus_addr - ADDR_W'(CFG_W)) >> 1);
    rd_cfg = cfg[rd_idx];
    if (bus_addr >= ADDR_W'(CFG_W) && bus_addr <= ADDR_W'(CFG_LAST)) begin
      if (!bus_addr[0])
        rd_nx = {rd_cfg.out_lvl, in_q[rd_idx] & !rd_cfg.sense_off, 25'b0,
                 rd_cfg.trig_lvl, rd_cfg.trig_inv, rd_cfg.dir_in, rd_cfg.use_sel};
      else
        rd_nx = {29'b0, rd_cfg.sense_off, rd_cfg.pull};
    end else begin
      for (int w = 0; w < MAP_WORDS; w++) begin
        if (bus_addr == ADDR_W'(OWN_W + w))  rd_nx = own_pad[w*32 +: 32];
        if (bus_addr == ADDR_W'(STAT_W + w)) rd_nx = stat_pad[w*32 +: 32];
        if (bus_addr == ADDR_W'(EN_W + w))   rd_nx = en_pad[w*32 +: 32];
      end
      if (bus_addr == ADDR_W'(ROUTE_W)) rd_nx = 32'(route_q);
      if (bus_addr == ADDR_W'(GCFG_W))  rd_nx = glb_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nx;
  end
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk #(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [2*NUM_PINS-1:0] pad_fsel,
  input logic                  sense0,
  input logic [31:0]           owned_lo,
  input logic                  irq_wr_stat,
  input logic                  irq_wr_en
);
  logic [NUM_PINS-1:0] gpio_mask;
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
    assign gpio_mask[i] = (pad_fsel[2*i +: 2] == 2'b01);
  end

  // R3: a driven pad must be in GPIO use
  p_oe_gpio_r3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~gpio_mask) == '0);

  // R5: pin 0 input level reads 0 while its sensing is off
  p_sense_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'('h40) && !sense0) |=> !bus_rdata[30]);

  // R11: a hole between bitmap bases reads 0
  p_hole_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(3)) |=> (bus_rdata == '0));

  // R10: at most one forwarded strobe at a time
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_wr_stat, irq_wr_en}));

  // R10: a strobe only follows a bus write
  p_strobe_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_wr_stat || irq_wr_en) |-> $past(bus_we));

  // R7: ownership word 0 takes the written value
  p_owned_write_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(0)) |=> (owned_lo == $past(bus_wdata)));
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pad_oe      (pad_oe),
  .pad_fsel    (pad_fsel),
  .sense0      (pad_sense_en[0]),
  .owned_lo    (pin_owned[31:0]),
  .irq_wr_stat (irq_wr_stat),
  .irq_wr_en   (irq_wr_en)
);

// File: tb/gpio_cfg_bank_tb.sv
`timescale 1ns/1ps
module gpio_cfg_bank_tb;
  localparam int N = 95;

  logic          clk = 0;
  logic          rst = 1;
  logic [7:0]    bus_addr = 8'h03;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = 0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_sense_en;
  logic [2*N-1:0] pad_fsel;
  logic [N-1:0]  trig_level, trig_inv, pin_owned, pin_route;
  logic [31:0]   glb_cfg;
  logic [N-1:0]  irq_stat_i = '0, irq_en_i = '0;
  logic          irq_wr_stat, irq_wr_en;
  logic [1:0]    irq_wr_idx;
  logic [31:0]   irq_wr_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_cfg_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .pad_sense_en(pad_sense_en),
    .pad_fsel(pad_fsel), .trig_level(trig_level), .trig_inv(trig_inv),
    .pin_owned(pin_owned), .pin_route(pin_route), .glb_cfg(glb_cfg),
    .irq_stat_i(irq_stat_i), .irq_en_i(irq_en_i),
    .irq_wr_stat(irq_wr_stat), .irq_wr_en(irq_wr_en),
    .irq_wr_idx(irq_wr_idx), .irq_wr_data(irq_wr_data)
  );

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard for bus reads
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_issue = 0, rd_pend = 0;

  always @(posedge clk) rd_pend <= rd_issue;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      // R12: value belongs to the address presented one edge earlier
      chk(tag_q.pop_front(), 256'(bus_rdata), 256'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 8'h03;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; rd_issue = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 0; bus_addr = 8'h03;
  endtask

  function automatic logic [7:0] w1(int p); return 8'(8'h40 + 2 * p); endfunction
  function automatic logic [7:0] w2(int p); return 8'(8'h41 + 2 * p); endfunction

  function automatic logic [N-1:0] route_exp(logic [15:0] rw);
    logic [N-1:0] v = '0;
    for (int b = 0; b < 16; b++) begin
      int p = (b < 3) ? 8 + b : (b < 5) ? 13 + b - 3 : 45 + b - 5;
      if (rw[b]) v[p] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*N-1:0] fsel_rst;
    logic [N-1:0]   one7;
    for (int i = 0; i < N; i++) fsel_rst[2*i +: 2] = 2'b01;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 256'(pad_oe), 256'(0));
    chk("R1 sense", 256'(pad_sense_en), 256'(0));
    chk("R1 fsel", 256'(pad_fsel), 256'(fsel_rst));
    chk("R1 pulls", 256'(pad_pull_up | pad_pull_dn), 256'(0));
    chk("R1 owned", 256'(pin_owned), 256'(0));
    rd(w1(0), 32'h5, "R1 w1 pin0");
    rd(w2(94), 32'h4, "R1 w2 pin94");

    // R2 fields, bit 30 not writable
    wr(w1(5), 32'hFFFF_FFFF);
    chk("R2 trig_level", 256'(trig_level[5]), 256'(1));
    chk("R2 trig_inv", 256'(trig_inv[5]), 256'(1));
    chk("R2 fsel", 256'(pad_fsel[11:10]), 256'(3));
    rd(w1(5), 32'h8000_001F, "R2 readback");

    // R3 output enable rule
    wr(w1(7), 32'h8000_0001);
    one7 = '0; one7[7] = 1'b1;
    chk("R3 oe gpio out", 256'(pad_oe), 256'(one7));
    chk("R3 out level", 256'(pad_out[7]), 256'(1));
    wr(w1(7), 32'h0000_0002);
    chk("R3 oe native", 256'(pad_oe[7]), 256'(0));
    wr(w1(7), 32'h0000_0005);
    chk("R3 oe input", 256'(pad_oe[7]), 256'(0));

    // R4 pulls and sense enable
    wr(w2(3), 32'h2);
    chk("R4 pull up", 256'({pad_pull_up[3], pad_pull_dn[3], pad_sense_en[3]}), 256'(3'b101));
    wr(w2(3), 32'h1);
    chk("R4 pull down", 256'({pad_pull_up[3], pad_pull_dn[3]}), 256'(2'b01));
    wr(w2(3), 32'h3);
    chk("R4 pull none", 256'({pad_pull_up[3], pad_pull_dn[3]}), 256'(2'b00));
    rd(w2(3), 32'h3, "R4 readback");
    wr(w2(3), 32'h4);
    chk("R4 sense off", 256'(pad_sense_en[3]), 256'(0));

    // R5 sampled input
    wr(w2(3), 32'h0);
    pad_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(w1(3), 32'h4000_0005, "R5 sensed high");
    wr(w2(3), 32'h4);
    rd(w1(3), 32'h0000_0005, "R5 gated");
    pad_in[3] = 1'b0;
    wr(w2(3), 32'h0);
    wr(w1(3), 32'h4000_0005);
    repeat (2) @(negedge clk);
    rd(w1(3), 32'h0000_0005, "R2 bit30 ignored");

    // R6 last pin and isolation
    wr(w1(94), 32'h8000_0001);
    chk("R6 pin94 oe", 256'(pad_oe[94:93]), 256'(2'b10));
    rd(w2(94), 32'h4, "R6 pin94 w2");
    rd(w1(93), 32'h5, "R6 pin93 untouched");

    // R7 ownership map
    wr(8'h02, 32'hFFFF_FFFF);
    chk("R7 owned top", 256'(pin_owned[94:64]), 256'(31'h7FFF_FFFF));
    rd(8'h02, 32'h7FFF_FFFF, "R7 word2 bit31");
    wr(8'h00, 32'hA5A5_A5A5);
    chk("R7 owned low", 256'(pin_owned[31:0]), 256'(32'hA5A5_A5A5));
    rd(8'h00, 32'hA5A5_A5A5, "R7 word0");

    // R8 routing
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R8 route all", 256'(pin_route), 256'(route_exp(16'hFFFF)));
    chk("R8 route count", 256'($countones(pin_route)), 256'(16));
    rd(8'h04, 32'h0000_FFFF, "R8 readback");
    wr(8'h04, 32'h0000_0021);
    chk("R8 route sparse", 256'(pin_route), 256'(route_exp(16'h0021)));

    // R9 global word
    wr(8'h1F, 32'hDEAD_BEEF);
    chk("R9 glb out", 256'(glb_cfg), 256'(32'hDEAD_BEEF));
    rd(8'h1F, 32'hDEAD_BEEF, "R9 readback");

    // R10 interrupt words
    irq_stat_i = {31'h1234_5678, 64'h0};
    irq_en_i   = {63'h0, 32'h8000_0001};
    rd(8'h22, 32'h1234_5678, "R10 stat word2");
    rd(8'h24, 32'h8000_0001, "R10 en word0");
    wr(8'h25, 32'hCAFE_0001);
    chk("R10 en strobe", 256'({irq_wr_en, irq_wr_stat, irq_wr_idx, irq_wr_data}),
        256'({1'b1, 1'b0, 2'd1, 32'hCAFE_0001}));
    @(negedge clk);
    chk("R10 strobe one cycle", 256'({irq_wr_en, irq_wr_stat}), 256'(0));
    wr(8'h20, 32'h0000_00FF);
    chk("R10 stat strobe", 256'({irq_wr_en, irq_wr_stat, irq_wr_idx}), 256'({1'b0, 1'b1, 2'd0}));

    // R11 holes
    wr(8'h03, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'hFE, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h03, 32'h0, "R11 hole 03");
    rd(8'h30, 32'h0, "R11 hole 30");
    rd(8'hFE, 32'h0, "R11 hole FE");
    rd(8'h05, 32'h0, "R11 hole 05");
    rd(8'h00, 32'hA5A5_A5A5, "R11 own intact");
    chk("R11 glb intact", 256'(glb_cfg), 256'(32'hDEAD_BEEF));

    // R12 read latency: no change before the edge
    @(negedge clk);
    bus_addr = 8'h1F;
    #1;
    chk("R12 not yet", 256'(bus_rdata), 256'(0));
    @(negedge clk);
    chk("R12 after edge", 256'(bus_rdata), 256'(32'hDEAD_BEEF));
    bus_addr = 8'h03;

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule